// File: doc/BRIEF.md
# Resolver Signal Fault Monitor

This block supervises a resolver-to-digital tracking converter and reports its health on two active-low flags. One input is a stream of digital monitor-magnitude samples. A healthy, tracking converter holds that magnitude steady. If one channel is lost, the magnitude falls low. If it is over-driven, the magnitude rises high. If the sine and cosine amplitudes differ, the magnitude swings between two levels.

The block also watches three signed levels every cycle: the tracking error angle, the difference between the internal and output positions, and the velocity. From these it decides whether the converter has lost tracking.

The two flags together give one of three fault classes in priority order. A rising edge on the sample strobe clears the latched faults and restarts the running minimum and maximum of the monitor magnitude. All thresholds are parameters in LSBs.

Magnitude samples arrive on a valid/ready stream. A sample is taken in any cycle where `mon_valid` and `mon_ready` are both high. `mon_ready` is low for exactly one cycle: the cycle in which the strobe edge is seen. A sample offered in that cycle is not taken. The source must hold it, or it is dropped. There is no other back-pressure.

Top module: `resolver_fault_monitor`

## Requirements
- R1: A taken sample below `LOS_TH` drives {dos_n,lot_n} to 00 from the next cycle. It stays 00 until a strobe edge, whatever later samples do.
- R2: A taken sample above `OVR_TH` gives a DOS indication (dos_n low) from the next cycle. This is not latched. The next taken sample at or below `OVR_TH` removes this cause.
- R3: The block keeps the minimum and maximum of all samples taken since the last strobe edge. When maximum minus minimum exceeds `MM_TH`, dos_n latches low until a strobe edge.
- R4: A strobe edge is a cycle with `sample_strobe` high after a cycle with it low. At that edge the LOS, mismatch and over-range causes clear, the minimum resets to all ones and the maximum resets to zero. The flags reflect this from the next cycle. Holding the strobe high gives no further clears.
- R5: Tracking is declared lost from the next cycle when |err_angle| > `TRIP_LSB`, or |pos_delta| > `TRIP_LSB`, or |velocity| > `VEL_MAX`.
- R6: Once lost, tracking is restored only in a cycle with |err_angle| < `REL_LSB`, |pos_delta| < `REL_LSB` and |velocity| <= `VEL_MAX`. Between the two thresholds the state holds.
- R7: {dos_n,lot_n} is 00 for LOS, 01 for DOS, 10 for LOT and 11 for no fault. LOS outranks DOS, and DOS outranks LOT.
- R8: Reset gives the LOS indication 00 and a healthy tracking state. The LOS indication persists until the first strobe edge.
- R9: `mon_ready` is high in every cycle except a strobe-edge cycle. A sample with `mon_valid` low, or offered in the strobe-edge cycle, has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sample_strobe | input | 1 | Level input; its rising edge clears latched faults |
| mon_valid | input | 1 | Monitor sample valid |
| mon_ready | output | 1 | Monitor sample ready |
| mon_mag | input | MAG_W | Monitor magnitude, unsigned |
| err_angle | input | ANG_W | Tracking error angle, signed LSBs |
| pos_delta | input | ANG_W | Internal minus output position, signed LSBs |
| velocity | input | VEL_W | Velocity, signed LSBs |
| dos_n | output | 1 | Degradation flag, active low |
| lot_n | output | 1 | Tracking flag, active low |

## Verification
The hardest situation to reach is loss of tracking held inside the hysteresis band while the amplitude side stays clean. The stimulus first clears the latches and feeds a mid-range sample. It then ramps each signed level in single-LSB steps, up through the trip point and back down through the band to the release point. This shows that the flag holds between the thresholds.

The latched mismatch needs two samples far enough apart. The bench therefore sweeps a grid of sample pairs after each clear. It also offers a sample in the very cycle of the strobe edge, to confirm that the sample is refused.

// File: rtl/rfm_pkg.sv
package rfm_pkg;
  typedef enum logic [1:0] {
    FLT_LOS  = 2'b00,
    FLT_DOS  = 2'b01,
    FLT_LOT  = 2'b10,
    FLT_NONE = 2'b11
  } fault_code_t;
endpackage

// File: rtl/rfm_amp_monitor.sv
module rfm_amp_monitor #(
  parameter int MAG_W  = 12,
  parameter int LOS_TH = 1000,
  parameter int OVR_TH = 3500,
  parameter int MM_TH  = 400
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             take,
  input  logic [MAG_W-1:0] mag,
  output logic             los_o,
  output logic             dos_o
);
  localparam logic [MAG_W-1:0] LOS_V = MAG_W'(LOS_TH);
  localparam logic [MAG_W-1:0] OVR_V = MAG_W'(OVR_TH);
  localparam logic [MAG_W-1:0] MM_V  = MAG_W'(MM_TH);

  logic [MAG_W-1:0] min_q, max_q, nxt_min, nxt_max, spread;
  logic             los_q, mm_q, ovr_q;

  // Running extremes including the sample being taken.
  always_comb begin
    nxt_min = (mag < min_q) ? mag : min_q;
    nxt_max = (mag > max_q) ? mag : max_q;
    spread  = (nxt_max >= nxt_min) ? (nxt_max - nxt_min) : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      min_q <= '1;
      max_q <= '0;
      los_q <= 1'b1;
      mm_q  <= 1'b0;
      ovr_q <= 1'b0;
    end else if (clear) begin
      min_q <= '1;
      max_q <= '0;
      los_q <= 1'b0;
      mm_q  <= 1'b0;
      ovr_q <= 1'b0;
    end else if (take) begin
      min_q <= nxt_min;
      max_q <= nxt_max;
      los_q <= los_q | (mag < LOS_V);
      mm_q  <= mm_q | (spread > MM_V);
      ovr_q <= (mag > OVR_V);
    end
  end

  assign los_o = los_q;
  assign dos_o = mm_q | ovr_q;
endmodule

// File: rtl/rfm_track_monitor.sv
module rfm_track_monitor #(
  parameter int ANG_W    = 12,
  parameter int VEL_W    = 12,
  parameter int TRIP_LSB = 57,
  parameter int REL_LSB  = 11,
  parameter int VEL_MAX  = 1000
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic signed [ANG_W-1:0] err_angle,
  input  logic signed [ANG_W-1:0] pos_delta,
  input  logic signed [VEL_W-1:0] velocity,
  output logic                    lot_o
);
  localparam int NANG = 2;
  localparam logic [ANG_W-1:0] TRIP_V = ANG_W'(TRIP_LSB);
  localparam logic [ANG_W-1:0] REL_V  = ANG_W'(REL_LSB);
  localparam logic [VEL_W-1:0] VMAX_V = VEL_W'(VEL_MAX);

  logic signed [ANG_W-1:0] ang   [NANG];
  logic        [ANG_W-1:0] ang_m [NANG];
  logic [NANG-1:0] a_trip, a_calm;
  logic [VEL_W-1:0] vel_m;
  logic v_over, trip, calm, lot_q;

  assign ang[0] = err_angle;
  assign ang[1] = pos_delta;

  for (genvar i = 0; i < NANG; i++) begin : g_ang
    assign ang_m[i]  = ang[i][ANG_W-1] ? $unsigned(-ang[i]) : $unsigned(ang[i]);
    assign a_trip[i] = ang_m[i] > TRIP_V;
    assign a_calm[i] = ang_m[i] < REL_V;
  end

  assign vel_m  = velocity[VEL_W-1] ? $unsigned(-velocity) : $unsigned(velocity);
  assign v_over = vel_m > VMAX_V;
  assign trip   = (|a_trip) | v_over;
  assign calm   = (&a_calm) & ~v_over;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         lot_q <= 1'b0;
    else if (trip)      lot_q <= 1'b1;
    else if (calm)      lot_q <= 1'b0;
  end

  assign lot_o = lot_q;
endmodule

// File: rtl/rfm_fault_encode.sv
module rfm_fault_encode
  import rfm_pkg::*;
(
  input  logic los,
  input  logic dos,
  input  logic lot,
  output logic dos_n,
  output logic lot_n
);
  fault_code_t code;

  always_comb begin
    if (los)      code = FLT_LOS;
    else if (dos) code = FLT_DOS;
    else if (lot) code = FLT_LOT;
    else          code = FLT_NONE;
  end

  assign dos_n = code[1];
  assign lot_n = code[0];
endmodule

// File: rtl/resolver_fault_monitor.sv
module resolver_fault_monitor #(
  parameter int MAG_W    = 12,
  parameter int ANG_W    = 12,
  parameter int VEL_W    = 12,
  parameter int LOS_TH   = 1000,
  parameter int OVR_TH   = 3500,
  parameter int MM_TH    = 400,
  parameter int TRIP_LSB = 57,
  parameter int REL_LSB  = 11,
  parameter int VEL_MAX  = 1000
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    sample_strobe,
  input  logic                    mon_valid,
  output logic                    mon_ready,
  input  logic [MAG_W-1:0]        mon_mag,
  input  logic signed [ANG_W-1:0] err_angle,
  input  logic signed [ANG_W-1:0] pos_delta,
  input  logic signed [VEL_W-1:0] velocity,
  output logic                    dos_n,
  output logic                    lot_n
);
  logic strobe_q, clear, take, los, dos, lot;

  // Held high through reset does not count as an edge.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) strobe_q <= 1'b1;
    else        strobe_q <= sample_strobe;
  end

  assign clear     = sample_strobe & ~strobe_q;
  assign mon_ready = ~clear;
  assign take      = mon_valid & mon_ready;

  rfm_amp_monitor #(
    .MAG_W(MAG_W), .LOS_TH(LOS_TH), .OVR_TH(OVR_TH), .MM_TH(MM_TH)
  ) i_amp (
    .clk(clk), .rst_n(rst_n), .clear(clear), .take(take), .mag(mon_mag),
    .los_o(los), .dos_o(dos)
  );

  rfm_track_monitor #(
    .ANG_W(ANG_W), .VEL_W(VEL_W), .TRIP_LSB(TRIP_LSB),
    .REL_LSB(REL_LSB), .VEL_MAX(VEL_MAX)
  ) i_track (
    .clk(clk), .rst_n(rst_n), .err_angle(err_angle), .pos_delta(pos_delta),
    .velocity(velocity), .lot_o(lot)
  );

  rfm_fault_encode i_enc (
    .los(los), .dos(dos), .lot(lot), .dos_n(dos_n), .lot_n(lot_n)
  );
endmodule

// File: rtl/rfm_checker.sv
module rfm_checker #(
  parameter int MAG_W    = 12,
  parameter int ANG_W    = 12,
  parameter int LOS_TH   = 1000,
  parameter int OVR_TH   = 3500,
  parameter int TRIP_LSB = 57
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    sample_strobe,
  input logic                    mon_valid,
  input logic                    mon_ready,
  input logic [MAG_W-1:0]        mon_mag,
  input logic signed [ANG_W-1:0] err_angle,
  input logic                    dos_n,
  input logic                    lot_n
);
  localparam logic [MAG_W-1:0] LOS_V  = MAG_W'(LOS_TH);
  localparam logic [MAG_W-1:0] OVR_V  = MAG_W'(OVR_TH);
  localparam logic [ANG_W-1:0] TRIP_V = ANG_W'(TRIP_LSB);

  logic prev_strobe, edge_seen, took;
  logic [ANG_W-1:0] err_m;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_strobe <= 1'b1;
    else        prev_strobe <= sample_strobe;
  end

  assign edge_seen = sample_strobe && !prev_strobe;
  assign took      = mon_valid && mon_ready;
  assign err_m     = err_angle[ANG_W-1] ? $unsigned(-err_angle) : $unsigned(err_angle);

  AST_READY_LOW_ON_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    edge_seen |-> !mon_ready); // R9
  AST_READY_HIGH_OTHERWISE: assert property (@(posedge clk) disable iff (!rst_n)
    !edge_seen |-> mon_ready); // R9
  AST_LOW_SAMPLE_LOS: assert property (@(posedge clk) disable iff (!rst_n)
    (took && mon_mag < LOS_V) |=> (!dos_n && !lot_n)); // R1
  AST_LOS_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (!dos_n && !lot_n && !edge_seen) |=> (!dos_n && !lot_n)); // R1
  AST_HIGH_SAMPLE_DOS: assert property (@(posedge clk) disable iff (!rst_n)
    (took && mon_mag > OVR_V) |=> !dos_n); // R2
  AST_EDGE_RELEASES_DOS: assert property (@(posedge clk) disable iff (!rst_n)
    edge_seen |=> dos_n); // R4
  AST_ERR_TRIPS_LOT: assert property (@(posedge clk) disable iff (!rst_n)
    (err_m > TRIP_V) |=> (!lot_n || !dos_n)); // R5
endmodule

bind resolver_fault_monitor rfm_checker #(
  .MAG_W(MAG_W), .ANG_W(ANG_W), .LOS_TH(LOS_TH), .OVR_TH(OVR_TH), .TRIP_LSB(TRIP_LSB)
) i_rfm_checker (
  .clk(clk), .rst_n(rst_n), .sample_strobe(sample_strobe), .mon_valid(mon_valid),
  .mon_ready(mon_ready), .mon_mag(mon_mag), .err_angle(err_angle),
  .dos_n(dos_n), .lot_n(lot_n)
);

// File: tb/test_resolver_fault_monitor.sv
module test_resolver_fault_monitor;
  localparam int MW = 8, AW = 8, VW = 8;
  localparam int LOS = 40, OVR = 200, MM = 50, TRIP = 57, REL = 11, VMAX = 100;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sample_strobe = 1'b0;
  logic mon_valid = 1'b0;
  logic mon_ready;
  logic [MW-1:0] mon_mag = '0;
  logic signed [AW-1:0] err_angle = '0;
  logic signed [AW-1:0] pos_delta = '0;
  logic signed [VW-1:0] velocity = '0;
  logic dos_n, lot_n;

  int checks = 0;
  int errors = 0;

  // Bench-side expectation state
  bit m_los = 1, m_mm = 0, m_ovr = 0, m_lot = 0;
  int m_min = 255, m_max = 0;

  always #4 clk = ~clk;

  resolver_fault_monitor #(
    .MAG_W(MW), .ANG_W(AW), .VEL_W(VW), .LOS_TH(LOS), .OVR_TH(OVR),
    .MM_TH(MM), .TRIP_LSB(TRIP), .REL_LSB(REL), .VEL_MAX(VMAX)
  ) i_resolver_fault_monitor (
    .clk(clk), .rst_n(rst_n), .sample_strobe(sample_strobe), .mon_valid(mon_valid),
    .mon_ready(mon_ready), .mon_mag(mon_mag), .err_angle(err_angle),
    .pos_delta(pos_delta), .velocity(velocity), .dos_n(dos_n), .lot_n(lot_n)
  );

  function automatic int iabs(input int x);
    return (x < 0) ? -x : x;
  endfunction

  function automatic logic [1:0] exp_code();
    if (m_los) return 2'b00;
    if (m_mm || m_ovr) return 2'b01;
    if (m_lot) return 2'b10;
    return 2'b11;
  endfunction

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk_code(input string req);
    checks++;
    if ({dos_n, lot_n} !== exp_code()) begin
      errors++;
      $display("FAIL %s: flags actual %b expected %b", req, {dos_n, lot_n}, exp_code());
    end
  endtask

  task automatic chk_ready(input string req, input logic e);
    checks++;
    if (mon_ready !== e) begin
      errors++;
      $display("FAIL %s: mon_ready actual %b expected %b", req, mon_ready, e);
    end
  endtask

  task automatic do_clear();
    sample_strobe = 1'b1;
    #1 chk_ready("R9", 1'b0);
    tick();
    m_los = 0; m_mm = 0; m_ovr = 0; m_min = 255; m_max = 0;
    chk_ready("R9", 1'b1);
    sample_strobe = 1'b0;
    tick();
  endtask

  task automatic feed(input int m);
    mon_valid = 1'b1;
    mon_mag = MW'(m);
    tick();
    mon_valid = 1'b0;
    if (m < LOS) m_los = 1;
    if (m < m_min) m_min = m;
    if (m > m_max) m_max = m;
    if (m_max - m_min > MM) m_mm = 1;
    m_ovr = (m > OVR);
  endtask

  task automatic track(input int e, input int v, input int p, input string req);
    err_angle = AW'(e);
    velocity = VW'(v);
    pos_delta = AW'(p);
    tick();
    if (iabs(e) > TRIP || iabs(p) > TRIP || iabs(v) > VMAX) m_lot = 1;
    else if (iabs(e) < REL && iabs(p) < REL && iabs(v) <= VMAX) m_lot = 0;
    chk_code(req);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run did not complete");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1 chk_code("R8");
    repeat (5) tick();
    chk_code("R8");
    do_clear();
    chk_code("R8"); // healthy tracking after reset, 11
    // Held strobe: no second clear
    sample_strobe = 1'b1; tick(); m_los = 0; m_mm = 0; m_ovr = 0; m_min = 255; m_max = 0;
    feed(5); chk_code("R4");
    tick(); chk_code("R4");
    sample_strobe = 1'b0; tick();
    // Sweep of single samples
    for (int m = 0; m < 256; m++) begin
      do_clear();
      feed(m);
      chk_code(m < LOS ? "R1" : (m > OVR ? "R2" : "R7"));
    end
    // LOS stays latched
    do_clear(); feed(10); feed(100); feed(110); chk_code("R1");
    // Over-range not latched
    do_clear(); feed(210); chk_code("R2"); feed(190); chk_code("R2");
    // Mismatch latch
    do_clear(); feed(60); feed(120); chk_code("R3"); feed(90); chk_code("R3");
    do_clear(); chk_code("R4");
    // Pair grid
    for (int a = 0; a < 256; a += 17) begin
      for (int b = 0; b < 256; b += 17) begin
        do_clear(); feed(a); feed(b); chk_code("R3");
      end
    end
    // Ignored samples
    do_clear();
    mon_valid = 1'b0; mon_mag = 8'd3; tick(); chk_code("R9");
    mon_valid = 1'b1; mon_mag = 8'd3; sample_strobe = 1'b1;
    tick();
    m_los = 0; m_mm = 0; m_ovr = 0; m_min = 255; m_max = 0;
    mon_valid = 1'b0; sample_strobe = 1'b0;
    tick(); chk_code("R9");
    // Tracking sweeps with clean amplitude
    do_clear(); feed(100);
    for (int e = -128; e < 128; e++) track(e, 0, 0, "R5");
    for (int e = 127; e >= -128; e--) track(e, 0, 0, "R6");
    track(0, 0, 0, "R6");
    for (int p = 0; p < 128; p++) track(0, 0, p, "R5");
    for (int p = 127; p >= -128; p--) track(0, 0, p, "R6");
    track(0, 0, 0, "R6");
    for (int v = -128; v < 128; v++) track(0, v, 0, "R5");
    for (int v = 127; v >= 0; v--) track(0, v, 0, "R6");
    track(30, 50, 0, "R6");
    track(0, 120, 0, "R5");
    track(5, 120, 5, "R6"); // still over velocity limit
    track(5, 90, 5, "R6");
    // Priority overlaps
    track(80, 0, 0, "R7");
    feed(210); chk_code("R7");
    feed(20); chk_code("R7");
    do_clear(); chk_code("R7");
    track(0, 0, 0, "R7");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule